// File: doc/BRIEF.md
# SPI status and interrupt flag register

This block keeps the status byte and the interrupt request of an SPI peripheral. A shift engine next to it sends one-cycle event pulses: a transfer has completed, a receive overrun has happened, or another master drove the bus (mode fault). The block also gets a software trigger bit, the raw slave-select pin, the number of bits received so far in the current character, the programmed character length, and the enable and master/slave settings. From these it builds an 8-bit status word for the CPU to read. The CPU clears the sticky flags by writing ones.

The slave-select pin passes through a two-flop synchronizer. In slave mode, if slave select goes inactive (high) while a character is only partly shifted, the block sets an abort flag and the interrupt flag in the same cycle. While the peripheral is disabled, every status bit is held at its reset value and every event is ignored. The interrupt request output is the interrupt flag itself.

The reset input is asynchronous and active low. It is expected to arrive already synchronized to the clock on release.

Top module: `spi_stat_flags`

## Requirements
- R1: The status word has this layout: bit 7 is the interrupt flag, bit 6 overrun, bit 5 collision (mode fault), bit 4 slave abort, bits 3 and 2 always read 0, bit 1 transfer in progress, and bit 0 the synchronized slave-select level. After reset the status reads 8'h01.
- R2: When wr_en is high, a 1 in wr_data bit 7, 6, 5 or 4 clears that flag to 0 on the next clock. A 0 in a bit position leaves that flag unchanged.
- R3: While enable is 0, the status reads 8'h01. Events, writes, the busy input and the slave-select pin then have no effect. Flags set before disabling are gone after the first clock with enable low.
- R4: While enabled, the interrupt flag sets on the clock after xfer_done or sw_trigger is high.
- R5: While enabled, overrun_evt sets bit 6 and fault_evt sets bit 5 on the next clock. The flags stay set until they are cleared or the block is disabled.
- R6: In slave mode (slave_mode=1), the block detects a rising edge on the synchronized slave select while 0 < bit_cnt < num_bits. Bits 4 and 7 then set together, three clocks after the pin changes. No abort is raised in master mode, when bit_cnt is 0, or when bit_cnt equals num_bits.
- R7: If a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: Bit 1 equals xfer_busy while the block is enabled. It is read-only, and writing to it has no effect.
- R9: The output irq always equals status bit 7.
- R10: While enabled, bit 0 shows the slave-select pin level two clocks after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| ss_n_pin | input | 1 | Raw slave-select pin, active low |
| xfer_done | input | 1 | Transfer-complete pulse |
| overrun_evt | input | 1 | Receive overrun pulse |
| fault_evt | input | 1 | Multi-master mode-fault pulse |
| sw_trigger | input | 1 | Software interrupt trigger bit |
| xfer_busy | input | 1 | Transfer in progress from shift engine |
| bit_cnt | input | CNT_W | Bits received in current character |
| num_bits | input | CNT_W | Programmed character length, 1 to 8 |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Write data, ones clear flags in bits 7..4 |
| stat | output | 8 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the reserved bits read zero, that irq tracks bit 7, that bit 1 tracks the busy input, and that the status is forced to reset while disabled. They also check that each event sets its flag on the next clock, that a write of zero keeps a set flag, and that a detected slave-select edge mid-character raises abort and interrupt together. The bench scenarios show what no single-cycle property can. These are the three-clock latency from the pin to the abort flag and the two-clock latency to bit 0, the absence of an abort for a full character, an empty character or master mode, set-beats-clear collisions, and the loss of earlier flags across a disable and re-enable.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int FLAG_N  = 4;
  localparam int B_IRQ   = 7;
  localparam int B_OVR   = 6;
  localparam int B_COL   = 5;
  localparam int B_ABT   = 4;
  localparam int B_BUSY  = 1;
  localparam int B_SS    = 0;
  localparam int FLAG_LO = B_ABT;
endpackage

// File: rtl/ss_sync.sv
module ss_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level = s2_q;
  assign rise  = s2_q & ~prev_q;
endmodule

// File: rtl/abort_detect.sv
module abort_detect #(
  parameter int CNT_W = 4
) (
  input  logic             enable,
  input  logic             slave_mode,
  input  logic             ss_rise,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic [CNT_W-1:0] num_bits,
  output logic             abort
);
  logic partial;

  always_comb begin
    partial = (bit_cnt != '0) && (bit_cnt < num_bits);
    abort   = enable && slave_mode && ss_rise && partial;
  end
endmodule

// File: rtl/flag_cell.sv
module flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic d;

  always_comb begin
    if (!enable)   d = 1'b0;
    else if (set)  d = 1'b1;
    else if (clr)  d = 1'b0;
    else           d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              slave_mode,
  input  logic              ss_n_pin,
  input  logic              xfer_done,
  input  logic              overrun_evt,
  input  logic              fault_evt,
  input  logic              sw_trigger,
  input  logic              xfer_busy,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [CNT_W-1:0]  num_bits,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic              ss_level, ss_rise, abort;
  logic [FLAG_N-1:0] set_v, clr_v, flag_q;
  logic              unused_low_wr;

  assign unused_low_wr = ^wr_data[FLAG_LO-1:0];

  ss_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ss_n_pin),
    .level (ss_level),
    .rise  (ss_rise)
  );

  abort_detect #(.CNT_W(CNT_W)) u_abort (
    .enable     (enable),
    .slave_mode (slave_mode),
    .ss_rise    (ss_rise),
    .bit_cnt    (bit_cnt),
    .num_bits   (num_bits),
    .abort      (abort)
  );

  always_comb begin
    set_v[B_IRQ-FLAG_LO] = xfer_done | sw_trigger | abort;
    set_v[B_OVR-FLAG_LO] = overrun_evt;
    set_v[B_COL-FLAG_LO] = fault_evt;
    set_v[B_ABT-FLAG_LO] = abort;
    clr_v = {FLAG_N{wr_en}} & wr_data[STAT_W-1:FLAG_LO];
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .set    (set_v[g]),
      .clr    (clr_v[g]),
      .q      (flag_q[g])
    );
  end

  always_comb begin
    stat = '0;
    stat[STAT_W-1:FLAG_LO] = flag_q;
    stat[B_BUSY] = enable & xfer_busy;
    stat[B_SS]   = enable ? ss_level : 1'b1;
  end

  assign irq = flag_q[B_IRQ-FLAG_LO];
endmodule

// File: rtl/spi_stat_flags_chk.sv
module spi_stat_flags_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             slave_mode,
  input logic             xfer_done,
  input logic             overrun_evt,
  input logic             fault_evt,
  input logic             sw_trigger,
  input logic             xfer_busy,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [CNT_W-1:0] num_bits,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       stat,
  input logic             irq,
  input logic             ss_rise
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat[3:2] == 2'b00);

  p_disabled_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (stat[7:4] == 4'b0000));

  p_disabled_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (stat[1:0] == 2'b01));

  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (xfer_done || sw_trigger)) |=> stat[7]);

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && overrun_evt) |=> stat[6]);

  p_col_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fault_evt) |=> stat[5]);

  p_write0_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stat[6] && !(wr_en && wr_data[6])) |=> stat[6]);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_en && wr_data[5] && !fault_evt) |=> !stat[5]);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && slave_mode && ss_rise && bit_cnt != '0 && bit_cnt < num_bits)
      |=> (stat[4] && stat[7]));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] == (enable && xfer_busy));

  p_irq_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == stat[7]);
endmodule

bind spi_stat_flags spi_stat_flags_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/spi_stat_flags_tb_top.sv
module spi_stat_flags_tb_top;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable, slave_mode, ss_n_pin;
  logic             xfer_done, overrun_evt, fault_evt, sw_trigger, xfer_busy;
  logic [CNT_W-1:0] bit_cnt, num_bits;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic [7:0]       stat;
  logic             irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_stat_flags #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slave_mode(slave_mode),
    .ss_n_pin(ss_n_pin), .xfer_done(xfer_done), .overrun_evt(overrun_evt),
    .fault_evt(fault_evt), .sw_trigger(sw_trigger), .xfer_busy(xfer_busy),
    .bit_cnt(bit_cnt), .num_bits(num_bits), .wr_en(wr_en), .wr_data(wr_data),
    .stat(stat), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset();
    check("R1 reset stat", stat, 8'h01);
    check("R9 reset irq", {7'b0, irq}, 8'h00);
    enable = 1'b1;
    step();
    check("R1 enabled idle", stat, 8'h01);
  endtask

  task automatic t_irq_sources();
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
    check("R4 done sets irq", stat, 8'h81);
    check("R9 irq pin", {7'b0, irq}, 8'h01);
    wr(8'h80);
    check("R2 clear irq", stat, 8'h01);
    sw_trigger = 1'b1; step(); sw_trigger = 1'b0;
    check("R4 trigger sets irq", stat, 8'h81);
    wr(8'h80);
  endtask

  task automatic t_err_flags();
    overrun_evt = 1'b1; fault_evt = 1'b1; step();
    overrun_evt = 1'b0; fault_evt = 1'b0;
    check("R5 ovr and col", stat, 8'h61);
    step(3);
    check("R5 sticky", stat, 8'h61);
    wr(8'h20);
    check("R2 partial clear", stat, 8'h41);
    wr(8'h0F);
    check("R2 write zero keeps", stat, 8'h41);
    wr(8'hF0);
    check("R2 clear all", stat, 8'h01);
  endtask

  task automatic t_busy();
    xfer_busy = 1'b1; #1;
    check("R8 busy bit", stat, 8'h03);
    wr(8'hFF);
    check("R8 busy read-only", stat, 8'h03);
    xfer_busy = 1'b0; #1;
    check("R8 idle bit", stat, 8'h01);
  endtask

  task automatic t_collide();
    overrun_evt = 1'b1; wr(8'h40); overrun_evt = 1'b0;
    check("R7 set beats clear", stat, 8'h41);
    wr(8'h40);
  endtask

  task automatic t_disable();
    fault_evt = 1'b1; step(); fault_evt = 1'b0;
    enable = 1'b0;
    step();
    check("R3 disable drops flags", stat, 8'h01);
    xfer_done = 1'b1; overrun_evt = 1'b1; xfer_busy = 1'b1; ss_n_pin = 1'b0;
    step(3);
    check("R3 disabled ignores", stat, 8'h01);
    xfer_done = 1'b0; overrun_evt = 1'b0; xfer_busy = 1'b0;
    enable = 1'b1; #1;
    check("R3 reenable no stale flags", stat, 8'h00);
    ss_n_pin = 1'b1;
    step(3);
    check("R10 ss high again", stat, 8'h01);
  endtask

  task automatic t_ss_sync();
    ss_n_pin = 1'b0;
    step();
    check("R10 one clock still high", stat, 8'h01);
    step();
    check("R10 two clocks low", stat, 8'h00);
  endtask

  task automatic t_abort();
    slave_mode = 1'b1; bit_cnt = 4'd3; num_bits = 4'd8;
    ss_n_pin = 1'b1;
    step(2);
    check("R6 no abort after two clocks", stat, 8'h01);
    step();
    check("R6 abort and irq", stat, 8'h91);
    wr(8'h90);
    check("R6 cleared", stat, 8'h01);
  endtask

  task automatic t_no_abort(input logic mode, input logic [CNT_W-1:0] cnt, input string tag);
    ss_n_pin = 1'b0; step(3);
    slave_mode = mode; bit_cnt = cnt; num_bits = 4'd8;
    ss_n_pin = 1'b1; step(4);
    check(tag, stat, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; slave_mode = 1'b0; ss_n_pin = 1'b1;
    xfer_done = 1'b0; overrun_evt = 1'b0; fault_evt = 1'b0; sw_trigger = 1'b0;
    xfer_busy = 1'b0; bit_cnt = '0; num_bits = 4'd8; wr_en = 1'b0; wr_data = 8'h00;
    step(2);
    rst_n = 1'b1;
    step();
    t_reset();
    t_irq_sources();
    t_err_flags();
    t_busy();
    t_collide();
    t_disable();
    t_ss_sync();
    t_abort();
    t_no_abort(1'b1, 4'd8, "R6 full char no abort");
    t_no_abort(1'b1, 4'd0, "R6 empty char no abort");
    t_no_abort(1'b0, 4'd3, "R6 master no abort");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule